// File: doc/BRIEF.md
# Display and Refresh Address Sequencer

This block produces the background address stream that a memory controller interleaves with processor accesses. Every display/refresh memory slot reads one word and uses one bit of it. The same stream keeps the dynamic memory rows refreshed and scans an oscilloscope point display. A bit index walks across the bits of the word being shown. A word index walks across all words of one display frame. Pairs of consecutive words form one display line. The word index therefore also gives the current line number.

The controller tells the block when a slot belongs to it (`ref_active`) and when that slot is on its final clock (`ref_last`). On that final clock the block does three things. It emits a one-clock brightness pulse if the displayed bit is 1. It raises the line and frame sync strobes when a counter is about to wrap. It advances its counters. Lines in the lower part of the frame show a memory page picked by `page_sel`. The remaining lines show processor registers through a register-file address. The raster deflection and the register file itself lie outside the block.

Top module: `disp_refresh_seq`

## Requirements
- R1: After reset, `bit_idx` and `word_idx` are 0, and `hsync`, `vsync` and `video` are low while no slot is ending.
- R2: On each rising clock edge with `ref_active` and `ref_last` both high (a slot end), `bit_idx` advances by one. It counts 0 to 17 and then returns to 0.
- R3: `word_idx` advances by one on a slot end where `bit_idx` is 17, and holds on every other slot end. It counts 0 to 43 and then returns to 0.
- R4: When `ref_active` is low (a processor slot), or `ref_last` is low, neither counter changes, whatever `ref_last`, `page_sel` or the data inputs do.
- R5: `line_no` equals `word_idx` divided by 2, giving 0 to 21. `rf_sel` is 1 exactly when `line_no` is 16 or more.
- R6: `mem_addr` is `{page_sel, word_idx[4:0]}`, with `page_sel` in bits 8:5.
- R7: When `rf_sel` is 1, `rf_addr` is `{line_no - 16 (3 bits), word_idx[0]}`. When `rf_sel` is 0, `rf_addr` is 0.
- R8: `video` is high only during the final clock of a display/refresh slot, and only when the displayed bit is 1. The displayed bit is `mem_rdata[bit_idx]` on lines below 16 and `rf_rdata[bit_idx]` on lines 16 and up.
- R9: `hsync` is high exactly during a slot-end clock on which `bit_idx` is 17.
- R10: `vsync` is high exactly during a slot-end clock on which `bit_idx` is 17 and `word_idx` is 43. It is never high without `hsync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_active | input | 1 | Current memory slot is a display/refresh slot |
| ref_last | input | 1 | Final clock of the current memory slot |
| page_sel | input | 4 | Memory page shown on the lower display lines |
| mem_rdata | input | 18 | Word read from memory in this slot |
| rf_rdata | input | 18 | Word read from the register file in this slot |
| bit_idx | output | 5 | Bit within the word being displayed (0 to 17) |
| word_idx | output | 6 | Word within the frame (0 to 43) |
| line_no | output | 5 | Display line (0 to 21) |
| mem_addr | output | 9 | Memory/refresh address `{page_sel, word within page}` |
| rf_addr | output | 4 | Register-file address for the upper lines |
| rf_sel | output | 1 | Displayed word comes from the register file |
| hsync | output | 1 | Line sync strobe |
| vsync | output | 1 | Frame sync strobe |
| video | output | 1 | Brightness pulse |

## Verification
The bench builds the block with its default parameters: 18 bits per word, 44 words per frame, 2 words per line, 16 memory lines and a 4-bit page select. Neither counter modulus is a power of two, so the compare-and-clear counter variant is the one exercised. With these values a complete frame takes only 792 slot ends. The whole frame therefore fits in a short run, including both wraps and the change from memory lines to register lines at word 32. Slots of several clocks, interleaved with processor slots, show that counting is tied to the slot end and not to the clock.

// File: rtl/drs_pkg.sv
package drs_pkg;

   // Source of the word currently being displayed
   typedef enum logic {
      SRC_MEM = 1'b0,
      SRC_REG = 1'b1
   } src_e;

   // Index width for a count of n items, never below one bit
   function automatic int unsigned width_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/drs_wrap_counter.sv
module drs_wrap_counter #(
   parameter int unsigned MODULUS = 18,
   parameter int unsigned W       = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] count,
   output logic         at_last
);
   localparam logic [W-1:0] LAST = W'(MODULUS - 1);
   localparam bit POW2 = (MODULUS == (64'd1 << W));

   if (MODULUS < 2) begin : g_bad_mod
      $error("drs_wrap_counter: MODULUS must be at least 2");
   end
   if (MODULUS > (64'd1 << W)) begin : g_bad_width
      $error("drs_wrap_counter: W too narrow for MODULUS");
   end

   assign at_last = (count == LAST);

   if (POW2) begin : g_pow2
      // natural binary rollover, no compare in the next-state path
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   count <= '0;
         else if (adv) count <= count + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   count <= '0;
         else if (adv) count <= at_last ? '0 : count + 1'b1;
      end
   end

endmodule

// File: rtl/drs_addr_map.sv
module drs_addr_map #(
   parameter int unsigned WORD_W    = 6,
   parameter int unsigned WPL_W     = 1,
   parameter int unsigned LINE_W    = 5,
   parameter int unsigned MEM_LINES = 16,
   parameter int unsigned PAGE_W    = 4,
   parameter int unsigned MEMW_W    = 5,
   parameter int unsigned RF_W      = 4
) (
   input  logic [WORD_W-1:0]        word_idx,
   input  logic [PAGE_W-1:0]        page_sel,
   output logic [LINE_W-1:0]        line_no,
   output logic [PAGE_W+MEMW_W-1:0] mem_addr,
   output logic [RF_W-1:0]          rf_addr,
   output drs_pkg::src_e            src
);
   localparam int unsigned RLINE_W = RF_W - WPL_W;

   logic [LINE_W-1:0] rel_line;

   // line number: the word index with the word-within-line bits dropped
   assign line_no  = word_idx[WORD_W-1:WPL_W];
   assign src      = (line_no >= LINE_W'(MEM_LINES)) ? drs_pkg::SRC_REG
                                                     : drs_pkg::SRC_MEM;
   assign mem_addr = {page_sel, word_idx[MEMW_W-1:0]};
   assign rel_line = line_no - LINE_W'(MEM_LINES);

   always_comb begin
      rf_addr = '0;
      if (src == drs_pkg::SRC_REG)
         rf_addr = {rel_line[RLINE_W-1:0], word_idx[WPL_W-1:0]};
   end

endmodule

// File: rtl/drs_video.sv
module drs_video #(
   parameter int unsigned BITS  = 18,
   parameter int unsigned BIT_W = 5
) (
   input  logic             strobe,
   input  drs_pkg::src_e    src,
   input  logic [BITS-1:0]  mem_rdata,
   input  logic [BITS-1:0]  rf_rdata,
   input  logic [BIT_W-1:0] bit_idx,
   output logic             video
);
   logic [BITS-1:0] shown;
   logic            dot;

   assign shown = (src == drs_pkg::SRC_REG) ? rf_rdata : mem_rdata;

   always_comb begin
      dot = 1'b0;
      for (int i = 0; i < BITS; i++)
         if (bit_idx == BIT_W'(i)) dot = shown[i];
   end

   assign video = strobe & dot;

endmodule

// File: rtl/disp_refresh_seq.sv
module disp_refresh_seq #(
   parameter int unsigned BITS_PER_WORD   = 18,
   parameter int unsigned WORDS_PER_FRAME = 44,
   parameter int unsigned WORDS_PER_LINE  = 2,
   parameter int unsigned MEM_LINES       = 16,
   parameter int unsigned PAGE_W          = 4,
   localparam int unsigned LINES   = WORDS_PER_FRAME / WORDS_PER_LINE,
   localparam int unsigned BIT_W   = drs_pkg::width_for(BITS_PER_WORD),
   localparam int unsigned WORD_W  = drs_pkg::width_for(WORDS_PER_FRAME),
   localparam int unsigned WPL_W   = $clog2(WORDS_PER_LINE),
   localparam int unsigned LINE_W  = WORD_W - WPL_W,
   localparam int unsigned MEMW_W  = $clog2(MEM_LINES * WORDS_PER_LINE),
   localparam int unsigned RF_W    = drs_pkg::width_for(LINES - MEM_LINES) + WPL_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ref_active,
   input  logic                     ref_last,
   input  logic [PAGE_W-1:0]        page_sel,
   input  logic [BITS_PER_WORD-1:0] mem_rdata,
   input  logic [BITS_PER_WORD-1:0] rf_rdata,
   output logic [BIT_W-1:0]         bit_idx,
   output logic [WORD_W-1:0]        word_idx,
   output logic [LINE_W-1:0]        line_no,
   output logic [PAGE_W+MEMW_W-1:0] mem_addr,
   output logic [RF_W-1:0]          rf_addr,
   output logic                     rf_sel,
   output logic                     hsync,
   output logic                     vsync,
   output logic                     video
);
   // elaboration-time parameter checks
   if (WORDS_PER_LINE < 2 || (WORDS_PER_LINE & (WORDS_PER_LINE - 1)) != 0) begin : g_chk_wpl
      $error("disp_refresh_seq: WORDS_PER_LINE must be a power of two, at least 2");
   end
   if (WORDS_PER_FRAME % WORDS_PER_LINE != 0) begin : g_chk_frame
      $error("disp_refresh_seq: frame must hold whole lines");
   end
   if (MEM_LINES == 0 || MEM_LINES >= LINES) begin : g_chk_split
      $error("disp_refresh_seq: MEM_LINES must leave at least one register line");
   end
   if ((MEM_LINES & (MEM_LINES - 1)) != 0) begin : g_chk_page
      $error("disp_refresh_seq: MEM_LINES must be a power of two for page addressing");
   end
   if (PAGE_W < 1 || BITS_PER_WORD < 2) begin : g_chk_misc
      $error("disp_refresh_seq: PAGE_W and BITS_PER_WORD out of range");
   end

   logic          slot_end;
   logic          bit_last;
   logic          word_last;
   drs_pkg::src_e src;

   assign slot_end = ref_active & ref_last;

   drs_wrap_counter #(
      .MODULUS (BITS_PER_WORD),
      .W       (BIT_W)
   ) u_bit_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (slot_end),
      .count   (bit_idx),
      .at_last (bit_last)
   );

   drs_wrap_counter #(
      .MODULUS (WORDS_PER_FRAME),
      .W       (WORD_W)
   ) u_word_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (slot_end & bit_last),
      .count   (word_idx),
      .at_last (word_last)
   );

   drs_addr_map #(
      .WORD_W    (WORD_W),
      .WPL_W     (WPL_W),
      .LINE_W    (LINE_W),
      .MEM_LINES (MEM_LINES),
      .PAGE_W    (PAGE_W),
      .MEMW_W    (MEMW_W),
      .RF_W      (RF_W)
   ) u_map (
      .word_idx  (word_idx),
      .page_sel  (page_sel),
      .line_no   (line_no),
      .mem_addr  (mem_addr),
      .rf_addr   (rf_addr),
      .src       (src)
   );

   drs_video #(
      .BITS      (BITS_PER_WORD),
      .BIT_W     (BIT_W)
   ) u_video (
      .strobe    (slot_end),
      .src       (src),
      .mem_rdata (mem_rdata),
      .rf_rdata  (rf_rdata),
      .bit_idx   (bit_idx),
      .video     (video)
   );

   assign rf_sel = (src == drs_pkg::SRC_REG);
   assign hsync  = slot_end & bit_last;
   assign vsync  = slot_end & bit_last & word_last;

endmodule

// File: rtl/disp_refresh_seq_chk.sv
module disp_refresh_seq_chk #(
   parameter int unsigned BITS_PER_WORD   = 18,
   parameter int unsigned WORDS_PER_FRAME = 44,
   parameter int unsigned MEM_LINES       = 16,
   parameter int unsigned BIT_W           = 5,
   parameter int unsigned WORD_W          = 6,
   parameter int unsigned LINE_W          = 5,
   parameter int unsigned RF_W            = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_active,
   input logic              ref_last,
   input logic [BIT_W-1:0]  bit_idx,
   input logic [WORD_W-1:0] word_idx,
   input logic [LINE_W-1:0] line_no,
   input logic [RF_W-1:0]   rf_addr,
   input logic              rf_sel,
   input logic              hsync,
   input logic              vsync,
   input logic              video
);
   localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS_PER_WORD - 1);
   localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS_PER_FRAME - 1);

   logic step;
   assign step = ref_active & ref_last;

   // R1: reset leaves both counters at zero
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> (bit_idx == '0 && word_idx == '0) || !rst_n);

   a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
      step && bit_idx != BIT_LAST |=> bit_idx == $past(bit_idx) + 1'b1);

   a_r2_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      step && bit_idx == BIT_LAST |=> bit_idx == '0);

   a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      step && bit_idx == BIT_LAST && word_idx != WORD_LAST
      |=> word_idx == $past(word_idx) + 1'b1);

   a_r3_word_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      step && bit_idx == BIT_LAST && word_idx == WORD_LAST |=> word_idx == '0);

   a_r3_word_hold_midline: assert property (@(posedge clk) disable iff (!rst_n)
      step && bit_idx != BIT_LAST |=> $stable(word_idx));

   a_r4_hold_outside_slot_end: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(bit_idx) && $stable(word_idx));

   a_r5_sel_matches_line: assert property (@(posedge clk) disable iff (!rst_n)
      rf_sel == (line_no >= LINE_W'(MEM_LINES)));

   a_r7_rf_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_sel |-> rf_addr == '0);

   a_r8_video_in_slot_end: assert property (@(posedge clk) disable iff (!rst_n)
      video |-> step);

   a_r9_hsync_at_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> bit_idx == '0);

   a_r10_vsync_with_hsync: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> hsync);

   a_r10_vsync_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> word_idx == '0 && bit_idx == '0);

endmodule

bind disp_refresh_seq disp_refresh_seq_chk #(
   .BITS_PER_WORD   (BITS_PER_WORD),
   .WORDS_PER_FRAME (WORDS_PER_FRAME),
   .MEM_LINES       (MEM_LINES),
   .BIT_W           (BIT_W),
   .WORD_W          (WORD_W),
   .LINE_W          (LINE_W),
   .RF_W            (RF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_active (ref_active),
   .ref_last   (ref_last),
   .bit_idx    (bit_idx),
   .word_idx   (word_idx),
   .line_no    (line_no),
   .rf_addr    (rf_addr),
   .rf_sel     (rf_sel),
   .hsync      (hsync),
   .vsync      (vsync),
   .video      (video)
);

// File: tb/disp_refresh_seq_test.sv
module disp_refresh_seq_test;

   localparam int BITS  = 18;
   localparam int WORDS = 44;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_active = 1'b0;
   logic        ref_last = 1'b0;
   logic [3:0]  page_sel = '0;
   logic [17:0] mem_rdata = '0;
   logic [17:0] rf_rdata = '0;
   logic [4:0]  bit_idx;
   logic [5:0]  word_idx;
   logic [4:0]  line_no;
   logic [8:0]  mem_addr;
   logic [3:0]  rf_addr;
   logic        rf_sel, hsync, vsync, video;

   always #10 clk = ~clk;   // 50 MHz

   disp_refresh_seq uut (
      .clk(clk), .rst_n(rst_n), .ref_active(ref_active), .ref_last(ref_last),
      .page_sel(page_sel), .mem_rdata(mem_rdata), .rf_rdata(rf_rdata),
      .bit_idx(bit_idx), .word_idx(word_idx), .line_no(line_no),
      .mem_addr(mem_addr), .rf_addr(rf_addr), .rf_sel(rf_sel),
      .hsync(hsync), .vsync(vsync), .video(video)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int exp_bit  = 0;
   int exp_word = 0;

   typedef struct packed {
      logic [31:0] skip;
      logic [3:0]  page;
      logic [17:0] mdat;
      logic [17:0] rdat;
      logic [31:0] ebit;
      logic [31:0] eword;
   } vec_t;

   // slot-end counts to run, data pattern, expected counters afterwards
   localparam vec_t VECS [6] = '{
      '{32'd1,   4'h3, 18'h2A5C3, 18'h15A3C, 32'd1,  32'd0},
      '{32'd16,  4'hA, 18'h3FFFF, 18'h00000, 32'd17, 32'd0},
      '{32'd1,   4'h5, 18'h00001, 18'h20000, 32'd0,  32'd1},
      '{32'd35,  4'hF, 18'h1248F, 18'h2DB70, 32'd17, 32'd2},
      '{32'd701, 4'h0, 18'h0F0F0, 18'h30F0F, 32'd16, 32'd41},
      '{32'd38,  4'h9, 18'h33333, 18'h0CCCC, 32'd0,  32'd0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // check combinational outputs on a slot-end clock against the model
   task automatic check_slot_end();
      int  line;
      bit  isrf;
      int  e_rf;
      bit  e_vid;
      line  = exp_word / 2;
      isrf  = (line >= 16);
      e_rf  = isrf ? ((line - 16) * 2 + exp_word % 2) : 0;
      e_vid = isrf ? rf_rdata[exp_bit] : mem_rdata[exp_bit];
      chk(int'(bit_idx) == exp_bit,  "R2 bit_idx", int'(bit_idx), exp_bit);
      chk(int'(word_idx) == exp_word, "R3 word_idx", int'(word_idx), exp_word);
      chk(int'(line_no) == line, "R5 line_no", int'(line_no), line);
      chk(rf_sel == isrf, "R5 rf_sel", int'(rf_sel), int'(isrf));
      chk(int'(mem_addr) == int'(page_sel) * 32 + exp_word % 32, "R6 mem_addr",
          int'(mem_addr), int'(page_sel) * 32 + exp_word % 32);
      chk(int'(rf_addr) == e_rf, "R7 rf_addr", int'(rf_addr), e_rf);
      chk(video == e_vid, "R8 video", int'(video), int'(e_vid));
      chk(hsync == (exp_bit == 17), "R9 hsync", int'(hsync), int'(exp_bit == 17));
      chk(vsync == (exp_bit == 17 && exp_word == 43), "R10 vsync",
          int'(vsync), int'(exp_bit == 17 && exp_word == 43));
   endtask

   task automatic model_step();
      if (exp_bit == BITS - 1) begin
         exp_bit  = 0;
         exp_word = (exp_word == WORDS - 1) ? 0 : exp_word + 1;
      end else begin
         exp_bit++;
      end
   endtask

   // one memory slot of n clocks; ref slots are checked on their last clock
   task automatic run_slot(input int n, input bit is_ref);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ref_active = is_ref;
         ref_last   = (i == n - 1);
         #1;
         if (is_ref && i == n - 1) check_slot_end();
         else begin
            chk(video == 1'b0, "R8 no video outside slot end", int'(video), 0);
            chk(hsync == 1'b0, "R9 no hsync outside slot end", int'(hsync), 0);
         end
      end
      if (is_ref) model_step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(bit_idx == 0, "R1 reset bit_idx", int'(bit_idx), 0);
      chk(word_idx == 0, "R1 reset word_idx", int'(word_idx), 0);
      chk(!hsync && !vsync && !video, "R1 reset strobes",
          int'({hsync, vsync, video}), 0);
      rst_n = 1'b1;

      // table walk: processor slot between every refresh slot
      foreach (VECS[v]) begin
         page_sel  = VECS[v].page;
         mem_rdata = VECS[v].mdat;
         rf_rdata  = VECS[v].rdat;
         for (int s = 0; s < int'(VECS[v].skip); s++) begin
            run_slot(2, 1'b1);
            run_slot(1, 1'b0);
         end
         @(negedge clk);
         ref_active = 1'b0; ref_last = 1'b0;
         #1;
         chk(int'(bit_idx) == int'(VECS[v].ebit), "R2 table bit_idx",
             int'(bit_idx), int'(VECS[v].ebit));
         chk(int'(word_idx) == int'(VECS[v].eword), "R3 table word_idx",
             int'(word_idx), int'(VECS[v].eword));
      end

      // R4: processor slots with ref_last pulses and toggling data move nothing
      for (int k = 0; k < 5; k++) begin
         page_sel  = 4'(k);
         mem_rdata = ~mem_rdata;
         run_slot(3, 1'b0);
      end
      @(negedge clk);
      ref_active = 1'b1; ref_last = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      chk(int'(bit_idx) == exp_bit, "R4 hold bit_idx", int'(bit_idx), exp_bit);
      chk(int'(word_idx) == exp_word, "R4 hold word_idx", int'(word_idx), exp_word);
      chk(video == 1'b0, "R4 no video without slot end", int'(video), 0);

      // long refresh slots across a full frame wrap with alternating data
      for (int s = 0; s < 2 * BITS * WORDS; s++) begin
         mem_rdata = (s % 3 == 0) ? 18'h2AAAA : 18'h15555;
         rf_rdata  = ~mem_rdata;
         page_sel  = 4'(s % 16);
         run_slot((s % 4) + 1, 1'b1);
         if (s % 5 == 0) run_slot(2, 1'b0);
      end

      // R1: reset mid-frame returns counters to zero
      @(negedge clk);
      ref_active = 1'b0; ref_last = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(bit_idx == 0 && word_idx == 0, "R1 async reset",
          int'({word_idx, bit_idx}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_bit = 0; exp_word = 0;
      run_slot(1, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule